// File: doc/BRIEF.md
# Store Write Buffer Controller

This block sits between the load/store stage of a processor pipeline and a memory bus. Each memory request carries an address, store data, byte enables, a load/store flag and a flag that says whether the target region tolerates buffering. A store to a bufferable region goes into a small in-order queue. The pipeline is released in the same cycle, so the store costs only its address-generation cycle. The data then appears on the bus while the next instruction executes.

Stores to regions that cannot be buffered take a different path. So do all stores while buffering is switched off. Such a store first waits until every queued entry has drained, so ordering is kept. It then goes out through a single direct slot and stays outstanding until the bus takes it. While that direct store is in flight, the pipeline is stalled only if it issues another load or store. A load whose word address matches a queued store is held until that entry has left the queue.

The bus side is a plain valid/ready port. The queue exports a registered full flag and an empty flag.

Top module: `store_wbuf`

## Requirements
- R1: A store with bufferable=1 and enable=1, issued while the queue is not full and no direct store is pending, is accepted without stall and is presented on the bus from the next cycle at the earliest.
- R2: wb_full is a registered flag that rises in the cycle after the push that fills the last of DEPTH entries. While it is high, a bufferable store with enable=1 is stalled. wb_full and wb_empty are never high together.
- R3: When the queue is full and the bus takes an entry (bus_ready=1), the waiting bufferable store is stalled for exactly that one cycle and accepted in the next, so it costs two cycles in total.
- R4: A store with bufferable=0 is stalled until the queue is empty. It is then accepted and driven on the bus from the next cycle.
- R5: While a direct store is outstanding, every request (req_valid=1) is stalled. stall is never high without req_valid. A request issued in the cycle after the bus takes the direct store is not stalled for that reason.
- R6: Queued entries leave on the bus in the order they were accepted.
- R7: A load (req_is_store=0) is stalled while any queued entry has the same word address. The word address is the address without its low log2(DW/8) byte-offset bits. A load that matches no queued entry is not stalled.
- R8: While bus_valid=1 and bus_ready=0, bus_valid, bus_addr, bus_data and bus_be hold their values. An entry leaves only when valid and ready are both high.
- R9: During and after reset, wb_empty=1, wb_full=0, bus_valid=0 and stall=0 while no request is made. Entries present before reset are discarded.
- R10: With buf_en=0, a store marked bufferable is handled exactly as a store with bufferable=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_en | input | 1 | Buffering enable |
| req_valid | input | 1 | A load or store is issued this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_bufferable | input | 1 | Target region may be buffered |
| req_addr | input | AW | Byte address of the request |
| req_data | input | DW | Store data |
| req_be | input | DW/8 | Store byte enables |
| stall | output | 1 | Hold the request, it was not accepted |
| bus_valid | output | 1 | A write is offered on the bus |
| bus_addr | output | AW | Write address |
| bus_data | output | DW | Write data |
| bus_be | output | DW/8 | Write byte enables |
| bus_ready | input | 1 | Bus takes the offered write this cycle |
| wb_full | output | 1 | Queue holds DEPTH entries (registered) |
| wb_empty | output | 1 | Queue holds no entries |

## Verification
stall responds to the request and the current state within the same cycle. The bench drives each request shortly after a rising edge and compares stall near the end of that same cycle. A store accepted at an edge, and the state changes that come from it, appear one edge later: the entry on bus_valid/bus_addr, the rise of wb_full, and the release of a held request. The stimulus table therefore gives, for every cycle, the outputs expected before the edge that closes it. Each row's expectation is worked out from the accepts and bus handshakes of the earlier rows.

// File: rtl/store_wbuf.sv
module store_wbuf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            buf_en,
  input  logic            req_valid,
  input  logic            req_is_store,
  input  logic            req_bufferable,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_data,
  input  logic [DW/8-1:0] req_be,
  output logic            stall,
  output logic            bus_valid,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_data,
  output logic [DW/8-1:0] bus_be,
  input  logic            bus_ready,
  output logic            wb_full,
  output logic            wb_empty
);
  localparam int BW  = DW / 8;
  localparam int OFS = (BW > 1) ? $clog2(BW) : 0;
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);

  logic [AW-1:0]    q_addr [DEPTH];
  logic [DW-1:0]    q_data [DEPTH];
  logic [BW-1:0]    q_be   [DEPTH];
  logic [DEPTH-1:0] q_vld;
  logic [DEPTH-1:0] hit_vec;
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt, cnt_n;
  logic             full_q;

  logic             dir_v;
  logic [AW-1:0]    dir_addr;
  logic [DW-1:0]    dir_data;
  logic [BW-1:0]    dir_be;

  wire is_st  = req_valid & req_is_store;
  wire is_ld  = req_valid & ~req_is_store;
  wire direct = ~buf_en | ~req_bufferable;
  wire q_any  = (cnt != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign hit_vec[i] = q_vld[i] && (q_addr[i][AW-1:OFS] == req_addr[AW-1:OFS]);
  end

  assign stall = req_valid & (dir_v
                 | (is_st & (direct ? q_any : full_q))
                 | (is_ld & (|hit_vec)));

  wire accept   = req_valid & ~stall;
  wire push     = accept & is_st & ~direct;
  wire dpush    = accept & is_st & direct;
  assign bus_valid = dir_v | q_any;
  wire fire     = bus_valid & bus_ready;
  wire pop      = fire & ~dir_v;

  assign bus_addr = dir_v ? dir_addr : q_addr[rp];
  assign bus_data = dir_v ? dir_data : q_data[rp];
  assign bus_be   = dir_v ? dir_be   : q_be[rp];

  assign cnt_n    = cnt + CW'(push) - CW'(pop);
  assign wb_full  = full_q;
  assign wb_empty = ~q_any;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      full_q <= 1'b0;
      q_vld  <= '0;
    end else begin
      cnt    <= cnt_n;
      full_q <= (cnt_n == CW'(DEPTH));
      if (push) begin
        q_addr[wp] <= req_addr;
        q_data[wp] <= req_data;
        q_be[wp]   <= req_be;
        wp         <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      for (int i = 0; i < DEPTH; i++) begin
        if (push && wp == PW'(i))     q_vld[i] <= 1'b1;
        else if (pop && rp == PW'(i)) q_vld[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_v <= 1'b0;
    end else if (dpush) begin
      dir_v    <= 1'b1;
      dir_addr <= req_addr;
      dir_data <= req_data;
      dir_be   <= req_be;
    end else if (fire && dir_v) begin
      dir_v <= 1'b0;
    end
  end
endmodule

// File: rtl/store_wbuf_chk.sv
module store_wbuf_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            buf_en,
  input logic            req_valid,
  input logic            req_is_store,
  input logic            req_bufferable,
  input logic            stall,
  input logic            bus_valid,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_data,
  input logic [DW/8-1:0] bus_be,
  input logic            bus_ready,
  input logic            wb_full,
  input logic            wb_empty,
  input logic            dir_v
);
  wire buf_st = req_valid & req_is_store & req_bufferable & buf_en;

  p_room_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    buf_st && !wb_full && !dir_v |-> !stall);

  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_st && wb_full |-> stall);

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_full && wb_empty));

  p_direct_after_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_v |-> wb_empty);

  p_pending_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dir_v && req_valid |-> stall);

  p_idle_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !stall);

  p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                && $stable(bus_data) && $stable(bus_be));
endmodule

bind store_wbuf store_wbuf_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .req_valid(req_valid),
  .req_is_store(req_is_store), .req_bufferable(req_bufferable), .stall(stall),
  .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be),
  .bus_ready(bus_ready), .wb_full(wb_full), .wb_empty(wb_empty), .dir_v(dir_v)
);

// File: tb/store_wbuf_tb.sv
module store_wbuf_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int NV = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_en = 1'b1, req_valid = 1'b0, req_is_store = 1'b0, req_bufferable = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [3:0] req_be = '0;
  logic bus_ready = 1'b0;
  logic stall, bus_valid, wb_full, wb_empty;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic [3:0] bus_be;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  store_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .req_valid(req_valid),
    .req_is_store(req_is_store), .req_bufferable(req_bufferable),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .stall(stall),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_be(bus_be), .bus_ready(bus_ready), .wb_full(wb_full), .wb_empty(wb_empty)
  );

  // {valid,store,bufferable,enable,ready, addr, exp stall,busvalid, exp busaddr, exp full,empty}
  localparam logic [40:0] VEC [NV] = '{
    {5'b00010, 16'h0000, 2'b00, 16'h0000, 2'b01},  // R9 idle
    {5'b11110, 16'h0010, 2'b00, 16'h0000, 2'b01},  // R1 accept, not yet on bus
    {5'b11110, 16'h0014, 2'b01, 16'h0010, 2'b00},  // R1
    {5'b11110, 16'h0018, 2'b01, 16'h0010, 2'b00},  // R6 head held
    {5'b11110, 16'h001C, 2'b01, 16'h0010, 2'b00},  // R1 fourth push
    {5'b11110, 16'h0020, 2'b11, 16'h0010, 2'b10},  // R2 full blocks
    {5'b11111, 16'h0020, 2'b11, 16'h0010, 2'b10},  // R3 bus takes one
    {5'b11110, 16'h0020, 2'b01, 16'h0014, 2'b00},  // R3 accepted next cycle
    {5'b10010, 16'h0018, 2'b11, 16'h0014, 2'b10},  // R7 load hits queue
    {5'b10010, 16'h0040, 2'b01, 16'h0014, 2'b10},  // R7 load misses
    {5'b00011, 16'h0000, 2'b01, 16'h0014, 2'b10},  // R6
    {5'b00011, 16'h0000, 2'b01, 16'h0018, 2'b00},  // R6
    {5'b10010, 16'h0018, 2'b01, 16'h001C, 2'b00},  // R7 drained, free
    {5'b11011, 16'h0100, 2'b11, 16'h001C, 2'b00},  // R4 waits for drain
    {5'b11011, 16'h0100, 2'b11, 16'h0020, 2'b00},  // R4
    {5'b11010, 16'h0100, 2'b00, 16'h0000, 2'b01},  // R4 accepted
    {5'b10010, 16'h0200, 2'b11, 16'h0100, 2'b01},  // R5 pending blocks load
    {5'b00010, 16'h0000, 2'b01, 16'h0100, 2'b01},  // R5 no request, no stall
    {5'b10011, 16'h0200, 2'b11, 16'h0100, 2'b01},  // R5 completes
    {5'b10010, 16'h0200, 2'b00, 16'h0000, 2'b01},  // R5 released
    {5'b11100, 16'h0300, 2'b00, 16'h0000, 2'b01},  // R10 disabled -> direct
    {5'b11100, 16'h0304, 2'b11, 16'h0300, 2'b01},  // R10
    {5'b11101, 16'h0304, 2'b11, 16'h0300, 2'b01},  // R10
    {5'b11100, 16'h0304, 2'b00, 16'h0000, 2'b01},  // R10
    {5'b00011, 16'h0000, 2'b01, 16'h0304, 2'b01},  // R10
    {5'b00010, 16'h0000, 2'b00, 16'h0000, 2'b01}   // R10
  };
  localparam int TAG [NV] = '{9,1,1,6,1,2,3,3,7,7,6,6,7,4,4,4,5,5,5,5,10,10,10,10,10,10};

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, st, bf, en, rdy, input logic [AW-1:0] a);
    req_valid = v; req_is_store = st; req_bufferable = bf; buf_en = en; bus_ready = rdy;
    req_addr = a; req_data = {16'hA5A5, a}; req_be = a[5:2] | 4'b0001;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("stall in reset", 9, 32'(stall), 0);     // R9
    check("empty in reset", 9, 32'(wb_empty), 1);  // R9
    check("bus_valid in reset", 9, 32'(bus_valid), 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      logic [15:0] ea;
      v = VEC[i];
      ea = v[17:2];
      drive(v[40], v[39], v[38], v[37], v[36], v[35:20]);
      #7;
      check($sformatf("row %0d stall", i), TAG[i], 32'(stall), 32'(v[19]));
      check($sformatf("row %0d bus_valid", i), TAG[i], 32'(bus_valid), 32'(v[18]));
      check($sformatf("row %0d full", i), TAG[i], 32'(wb_full), 32'(v[1]));
      check($sformatf("row %0d empty", i), TAG[i], 32'(wb_empty), 32'(v[0]));
      if (v[18]) begin
        check($sformatf("row %0d bus_addr", i), TAG[i], 32'(bus_addr), 32'(ea));
        check($sformatf("row %0d bus_data", i), TAG[i], bus_data, {16'hA5A5, ea});  // R8
        check($sformatf("row %0d bus_be", i), TAG[i], 32'(bus_be), 32'(ea[5:2] | 4'b0001));
      end
      @(posedge clk);
      #1;
    end

    // R7: byte offset ignored in the hazard compare
    drive(1, 1, 1, 1, 0, 16'h0050);
    @(posedge clk); #1;
    drive(1, 0, 0, 1, 0, 16'h0052);
    #7; check("load same word", 7, 32'(stall), 1);
    @(posedge clk); #1;
    drive(1, 0, 0, 1, 0, 16'h0054);
    #7; check("load next word", 7, 32'(stall), 0);
    @(posedge clk); #1;

    // R9: entries dropped by reset
    drive(1, 1, 1, 1, 0, 16'h0060);
    @(posedge clk); #1;
    drive(0, 0, 0, 1, 0, 16'h0000);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    #7;
    check("empty after reset", 9, 32'(wb_empty), 1);
    check("full after reset", 9, 32'(wb_full), 0);
    check("bus idle after reset", 9, 32'(bus_valid), 0);
    check("no stall after reset", 9, 32'(stall), 0);
    @(posedge clk); #1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end
endmodule